// File: doc/BRIEF.md
# DMA Address Translation Table Walker

This block turns the address of a device's memory access into a host physical address. The block uses the requester ID of the access to find that device's tables in memory. The bus number picks an entry in a root table. That entry points to a context table. The device/function number then picks an entry in the context table, and that entry gives the root of a four-level page table. The walker follows the page table down to a page frame and joins the frame to the untranslated low bits of the input address. The result is returned together with a page-size code. If an entry along the way is missing, the walk stops and the block returns a fault with a reason code in place of an address.

Table entries are 64 bits wide and are fetched one at a time over a request/response read port. The block handles only one walk at a time. A new request is stalled until the consumer has taken the previous result. Two kinds of access skip translation. An interrupt-message write skips the walk entirely. A device whose context entry is marked pass-through gets its own address back unchanged. When the super-page enable input is high, a walk may also stop early on a 1 GB or 2 MB leaf.

Top module: `dma_xlate_walker`

## Requirements
- R1: The first read after a request is accepted is at address `{cfg_root_base[45:12], 12'b0} + bus*8`, where bus is `req_rid[15:8]`. In that root entry, bit 0 means present and bits 45:12 hold the context-table frame.
- R2: The second read is at context frame + devfn*8, where devfn is `req_rid[7:0]`. In the context entry, bit 0 means present, bit 1 selects pass-through, and bits 45:12 hold the frame of the top page table.
- R3: The page walk reads levels 4, 3, 2 and 1, in that order. Each level is indexed by input-address bits [47:39], [38:30], [29:21] and [20:12] respectively, scaled by 8. In each page entry, bit 0 means present and bits 45:12 hold the frame. A present level-1 entry gives the result `{frame[45:12], addr[11:0]}` with size code 0 (4 KB).
- R4: When `cfg_sp_en` is 1, a present entry with bit 7 set ends the walk early. At level 3 it gives a 1 GB page: `{frame[45:30], addr[29:0]}` with size code 2. At level 2 it gives a 2 MB page: `{frame[45:21], addr[20:0]}` with size code 1.
- R5: When `cfg_sp_en` is 0, bit 7 of a page entry is ignored. The entry's frame is used as the next table and the walk continues downward.
- R6: A root, context or page entry with bit 0 clear ends the walk with `rsp_fault`=1. The code is 0 for root, 1 for context and 2 for a page entry, and `rsp_addr` is zero.
- R7: A request with any of address bits 63:48 set faults with code 3 and makes no memory read. A pass-through device whose address has any of bits 63:46 set also faults with code 3.
- R8: A write whose address has bits 63:32 all zero and bits 31:20 equal to 0xFEE is returned as `addr[45:0]` with size code 3 and no memory read. A read to the same address is walked normally.
- R9: A present context entry with the pass-through bit set returns `addr[45:0]` unchanged with size code 3. The walk stops after the context read.
- R10: `req_ready` is high only while no walk is in flight. A result stays on the outputs, unchanged, until `rsp_ready` is seen high.
- R11: When the memory grants and answers at once, `rsp_valid` rises 1 + 2*F cycles after the accepting edge, where F is the number of entries read.
- R12: While `mem_req_ready` is low, `mem_req_valid` and `mem_req_addr` hold. Each wait cycle adds one cycle to the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_root_base | input | 46 | Root table base; bits 45:12 used |
| cfg_sp_en | input | 1 | Allows 1 GB / 2 MB leaves |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_rid | input | 16 | Requester ID, bus in 15:8, devfn in 7:0 |
| req_addr | input | 64 | Device address to translate |
| req_write | input | 1 | Access is a write |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 46 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Table entry |
| rsp_valid | output | 1 | Result or fault available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_code | output | 2 | Fault reason: 0 root, 1 context, 2 page entry, 3 width |
| rsp_addr | output | 46 | Host physical address (zero on fault) |
| rsp_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB, 3 = untranslated |

## Verification
Each read costs two cycles: one for the grant and one for the returned data. The bench memory answers one cycle after it grants a read. This puts `rsp_valid` at 1 cycle for a bypass or width fault, 3 for a root fault, 5 for a context fault or pass-through, 7, 9 and 11 for faults or leaves at levels 4, 3 and 2, and 13 for a full 4 KB walk. The bench counts rising edges from the accepting edge and samples on the falling edge in between. It compares that count, the result fields and the number of granted reads against these values. In the stall case, three grant-wait cycles are added and the bench expects them in the count.

// File: rtl/dmar_pkg.sv
// Shared constants and types for the DMA translation walker.
// Assumes 8-byte table entries, so index width + 3 equals the page shift.
package dmar_pkg;
    localparam int HPA_W   = 46;  // host physical address width
    localparam int GAW     = 48;  // translated guest address width
    localparam int IN_AW   = 64;  // request address width
    localparam int LEVELS  = 4;   // page table depth
    localparam int IDX_W   = 9;   // index bits per level
    localparam int PG_SH   = 12;  // base page shift
    localparam int LVL_W   = $clog2(LEVELS + 1);

    localparam int BIT_PRESENT = 0;
    localparam int BIT_FLAT    = 1;
    localparam int BIT_LEAF    = 7;

    typedef enum logic [1:0] {
        FLT_ROOT  = 2'd0,
        FLT_CTX   = 2'd1,
        FLT_PTE   = 2'd2,
        FLT_WIDTH = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        SZ_4K   = 2'd0,
        SZ_2M   = 2'd1,
        SZ_1G   = 2'd2,
        SZ_FLAT = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        STG_ROOT = 2'd0,
        STG_CTX  = 2'd1,
        STG_PT   = 2'd2
    } stage_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } fsm_e;
endpackage

// File: rtl/dmar_entry_decode.sv
// Splits a 64-bit table entry into its flags and frame number.
// Assumes the same layout for root, context and page entries.
module dmar_entry_decode
    import dmar_pkg::*;
#(
    parameter int AW = HPA_W,
    parameter int SH = PG_SH
) (
    input  logic [63:0]    entry,
    output logic           present,
    output logic           flat,
    output logic           leaf_hint,
    output logic [AW-1:SH] frame
);
    // field extraction
    assign present   = entry[BIT_PRESENT];
    assign flat      = entry[BIT_FLAT];
    assign leaf_hint = entry[BIT_LEAF];
    assign frame     = entry[AW-1:SH];

    logic unused_bits;
    assign unused_bits = ^{entry[63:AW], entry[SH-1:BIT_LEAF+1], entry[BIT_LEAF-1:BIT_FLAT+1]};
endmodule

// File: rtl/dmar_fetch_addr.sv
// Forms the byte address of the next entry to read from the current table
// frame and the index for the current stage. The root stage uses the bus,
// the context stage uses devfn, and page levels use 9-bit slices of the input address.
// Assumes IX + 3 == SH (8-byte entries fill one page).
module dmar_fetch_addr
    import dmar_pkg::*;
#(
    parameter int AW  = HPA_W,
    parameter int VW  = GAW,
    parameter int SH  = PG_SH,
    parameter int IX  = IDX_W,
    parameter int NL  = LEVELS,
    parameter int LW  = LVL_W
) (
    input  stage_e         stage,
    input  logic [LW-1:0]  level,
    input  logic [AW-1:SH] table_frame,
    input  logic [15:0]    rid,
    input  logic [VW-1:SH] va_pfn,
    output logic [AW-1:0]  addr
);
    logic [IX-1:0] lvl_idx [1:NL];
    logic [IX-1:0] idx;

    // one index slice per page level
    for (genvar g = 1; g <= NL; g++) begin : g_slice
        assign lvl_idx[g] = va_pfn[SH + IX*(g-1) +: IX];
    end

    // pick the index for the current stage and level
    always_comb begin
        idx = '0;
        case (stage)
            STG_ROOT: idx = IX'(rid[15:8]);
            STG_CTX:  idx = IX'(rid[7:0]);
            default: begin
                for (int l = 1; l <= NL; l++) begin
                    if (level == LW'(l)) idx = lvl_idx[l];
                end
            end
        endcase
    end

    assign addr = {table_frame, idx, 3'b000};
endmodule

// File: rtl/dmar_result_fmt.sv
// Merges a leaf frame with the untranslated offset bits for the page size.
// Assumes super-page frames are naturally aligned, so their low frame bits are dropped.
module dmar_result_fmt
    import dmar_pkg::*;
#(
    parameter int AW = HPA_W,
    parameter int SH = PG_SH,
    parameter int IX = IDX_W
) (
    input  size_e          size,
    input  logic [AW-1:SH] frame,
    input  logic [AW-1:0]  va,
    output logic [AW-1:0]  hpa
);
    localparam int SH_2M = SH + IX;
    localparam int SH_1G = SH + 2*IX;

    logic [AW-1:0] mask;

    // offset mask per page size
    always_comb begin
        case (size)
            SZ_4K:   mask = (AW'(1) << SH) - AW'(1);
            SZ_2M:   mask = (AW'(1) << SH_2M) - AW'(1);
            SZ_1G:   mask = (AW'(1) << SH_1G) - AW'(1);
            default: mask = '1;
        endcase
    end

    assign hpa = ({frame, {SH{1'b0}}} & ~mask) | (va & mask);
endmodule

// File: rtl/dma_xlate_walker.sv
// DMA address translation walker: bus -> root entry, devfn -> context entry,
// then a LEVELS-deep page walk to a host physical address.
// Handles one walk at a time. The memory port is request/response with at most
// one read outstanding. Interrupt-message writes and pass-through devices skip translation.
module dma_xlate_walker
    import dmar_pkg::*;
#(
    parameter int AW  = HPA_W,
    parameter int VW  = GAW,
    parameter int IAW = IN_AW,
    parameter int NL  = LEVELS,
    parameter int IX  = IDX_W,
    parameter int SH  = PG_SH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  cfg_root_base,
    input  logic           cfg_sp_en,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [15:0]    req_rid,
    input  logic [IAW-1:0] req_addr,
    input  logic           req_write,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [AW-1:0]  mem_req_addr,
    input  logic           mem_rsp_valid,
    input  logic [63:0]    mem_rsp_data,
    output logic           rsp_valid,
    input  logic           rsp_ready,
    output logic           rsp_fault,
    output logic [1:0]     rsp_code,
    output logic [AW-1:0]  rsp_addr,
    output logic [1:0]     rsp_size
);
    localparam int LW      = $clog2(NL + 1);
    localparam int SP_HIGH = NL - 1;  // highest level allowed to hold a super-page
    localparam logic [11:0] MSI_TAG = 12'hFEE;

    fsm_e            st_q;
    stage_e          stg_q;
    logic [LW-1:0]   lvl_q;
    logic [AW-1:SH]  tbl_q;
    logic [15:0]     rid_q;
    logic [IAW-1:0]  iova_q;
    logic            flt_q;
    fault_e          code_q;
    logic [AW-1:0]   addr_q;
    size_e           size_q;

    logic            e_present, e_flat, e_leaf;
    logic [AW-1:SH]  e_frame;
    logic [AW-1:0]   leaf_hpa;
    logic [LW-1:0]   lvl_m1;
    size_e           leaf_size;
    logic            sp_ok, pte_leaf;
    logic            is_msi, beyond_gaw, flat_wide;

    dmar_entry_decode #(.AW(AW), .SH(SH)) u_decode (
        .entry     (mem_rsp_data),
        .present   (e_present),
        .flat      (e_flat),
        .leaf_hint (e_leaf),
        .frame     (e_frame)
    );

    dmar_fetch_addr #(.AW(AW), .VW(VW), .SH(SH), .IX(IX), .NL(NL), .LW(LW)) u_fetch (
        .stage       (stg_q),
        .level       (lvl_q),
        .table_frame (tbl_q),
        .rid         (rid_q),
        .va_pfn      (iova_q[VW-1:SH]),
        .addr        (mem_req_addr)
    );

    dmar_result_fmt #(.AW(AW), .SH(SH), .IX(IX)) u_fmt (
        .size  (leaf_size),
        .frame (e_frame),
        .va    (iova_q[AW-1:0]),
        .hpa   (leaf_hpa)
    );

    // request classification at the accept point
    assign is_msi     = req_write && (req_addr[IAW-1:32] == '0) && (req_addr[31:20] == MSI_TAG);
    assign beyond_gaw = |req_addr[IAW-1:VW];
    assign flat_wide  = |iova_q[IAW-1:AW];

    // leaf detection for the current page level
    assign lvl_m1    = lvl_q - LW'(1);
    assign leaf_size = size_e'(lvl_m1[1:0]);
    assign sp_ok     = cfg_sp_en && e_leaf && (lvl_q >= LW'(2)) && (lvl_q <= LW'(SP_HIGH));
    assign pte_leaf  = (lvl_q == LW'(1)) || sp_ok;

    // walk sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            stg_q  <= STG_ROOT;
            lvl_q  <= LW'(NL);
            tbl_q  <= '0;
            rid_q  <= '0;
            iova_q <= '0;
            flt_q  <= 1'b0;
            code_q <= FLT_ROOT;
            addr_q <= '0;
            size_q <= SZ_4K;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        rid_q  <= req_rid;
                        iova_q <= req_addr;
                        tbl_q  <= cfg_root_base[AW-1:SH];
                        stg_q  <= STG_ROOT;
                        lvl_q  <= LW'(NL);
                        flt_q  <= 1'b0;
                        code_q <= FLT_ROOT;
                        addr_q <= '0;
                        size_q <= SZ_FLAT;
                        if (is_msi) begin
                            addr_q <= req_addr[AW-1:0];
                            st_q   <= ST_DONE;
                        end else if (beyond_gaw) begin
                            flt_q  <= 1'b1;
                            code_q <= FLT_WIDTH;
                            size_q <= SZ_4K;
                            st_q   <= ST_DONE;
                        end else begin
                            st_q   <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_req_ready) st_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        tbl_q <= e_frame;
                        st_q  <= ST_FETCH;
                        case (stg_q)
                            STG_ROOT: begin
                                stg_q <= STG_CTX;
                                if (!e_present) begin
                                    flt_q <= 1'b1; code_q <= FLT_ROOT; size_q <= SZ_4K; st_q <= ST_DONE;
                                end
                            end
                            STG_CTX: begin
                                stg_q <= STG_PT;
                                if (!e_present) begin
                                    flt_q <= 1'b1; code_q <= FLT_CTX; size_q <= SZ_4K; st_q <= ST_DONE;
                                end else if (e_flat) begin
                                    st_q <= ST_DONE;
                                    if (flat_wide) begin
                                        flt_q <= 1'b1; code_q <= FLT_WIDTH; size_q <= SZ_4K;
                                    end else begin
                                        addr_q <= iova_q[AW-1:0]; size_q <= SZ_FLAT;
                                    end
                                end
                            end
                            default: begin
                                if (!e_present) begin
                                    flt_q <= 1'b1; code_q <= FLT_PTE; size_q <= SZ_4K; st_q <= ST_DONE;
                                end else if (pte_leaf) begin
                                    addr_q <= leaf_hpa; size_q <= leaf_size; st_q <= ST_DONE;
                                end else begin
                                    lvl_q <= lvl_m1;
                                end
                            end
                        endcase
                    end
                end
                default: begin
                    if (rsp_ready) st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign mem_req_valid = (st_q == ST_FETCH);
    assign rsp_valid     = (st_q == ST_DONE);
    assign rsp_fault     = flt_q;
    assign rsp_code      = code_q;
    assign rsp_addr      = addr_q;
    assign rsp_size      = size_q;

    logic unused_base;
    assign unused_base = ^cfg_root_base[SH-1:0];

    // R12: a pending read holds its address until granted
    assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R10: a result is held until taken
    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_code) && $stable(rsp_fault));

    // R6: a fault never carries an address
    assert_fault_noaddr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_addr == '0);

    // R3: a 4 KB result keeps the page offset of the request
    assert_offset_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault && rsp_size == SZ_4K |-> rsp_addr[SH-1:0] == iova_q[SH-1:0]);

    // R7: a width fault only follows an address with bits above the host width
    assert_width_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault && rsp_code == FLT_WIDTH |-> |iova_q[IAW-1:AW]);
endmodule

// File: tb/test_dma_xlate_walker.sv
module test_dma_xlate_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [45:0] cfg_root_base = 46'h0000_0010_0000;
    logic        cfg_sp_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_rid = '0;
    logic [63:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [45:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [1:0]  rsp_code;
    logic [45:0] rsp_addr;
    logic [1:0]  rsp_size;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_xlate_walker i_dma_xlate_walker (
        .clk(clk), .rst_n(rst_n), .cfg_root_base(cfg_root_base), .cfg_sp_en(cfg_sp_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_rid(req_rid),
        .req_addr(req_addr), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_addr(rsp_addr), .rsp_size(rsp_size)
    );

    // memory model: optional grant delay, data one cycle after grant
    logic [63:0] mem [logic [45:0]];
    int stall_req = 0;
    int wait_cnt = 0;
    int rd_cnt = 0;
    assign mem_req_ready = (wait_cnt >= stall_req);

    always @(posedge clk) begin
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
            rd_cnt <= rd_cnt + 1;
            wait_cnt <= 0;
        end else if (mem_req_valid) begin
            wait_cnt <= wait_cnt + 1;
        end
    end

    localparam logic [45:0] CTX_A = 46'h0000_0020_0000;
    localparam logic [45:0] PT4_A = 46'h0000_0030_0000;
    localparam logic [45:0] PT3_A = 46'h0000_0030_1000;
    localparam logic [45:0] PT2_A = 46'h0000_0030_2000;
    localparam logic [45:0] PT1_A = 46'h0000_0030_3000;
    localparam logic [45:0] PG_A  = 46'h0012_3456_7000;
    localparam logic [45:0] PT4_B = 46'h0000_0031_0000;
    localparam logic [45:0] PT3_B = 46'h0000_0031_1000;
    localparam logic [45:0] PT2_B = 46'h0000_0031_2000;
    localparam logic [45:0] G1_B  = 46'h0040_0000_0000;
    localparam logic [45:0] M2_B  = 46'h0000_0060_0000;

    function automatic logic [63:0] va(input int l4, input int l3, input int l2, input int l1, input int off);
        return (64'(l4) << 39) | (64'(l3) << 30) | (64'(l2) << 21) | (64'(l1) << 12) | 64'(off);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // results of the last request
    logic        o_fault;
    logic [1:0]  o_code, o_size;
    logic [45:0] o_addr;
    int          o_lat, o_reads;
    bit          o_busy_bad, o_hold_bad, o_idle_after;

    task automatic run(input logic [15:0] rid, input logic [63:0] a, input bit wr, input int hold);
        int start;
        @(negedge clk);
        start = rd_cnt;
        req_valid = 1'b1; req_rid = rid; req_addr = a; req_write = wr;
        @(posedge clk);
        o_lat = 1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        o_busy_bad = 1'b0;
        while (!rsp_valid && o_lat < 200) begin
            if (req_ready) o_busy_bad = 1'b1;
            @(posedge clk);
            o_lat++;
            @(negedge clk);
        end
        o_fault = rsp_fault; o_code = rsp_code; o_addr = rsp_addr; o_size = rsp_size;
        o_hold_bad = 1'b0;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (!rsp_valid || rsp_addr !== o_addr || rsp_code !== o_code) o_hold_bad = 1'b1;
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        o_idle_after = req_ready && !rsp_valid;
        o_reads = rd_cnt - start;
    endtask

    task automatic t_reset;
        chk("R10 reset req_ready", 64'(req_ready), 64'd1);
        chk("R10 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R12 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_walk_4k;
        run({8'd5, 8'h1A}, va(1, 2, 3, 4, 'hABC), 1'b0, 3);
        chk("R1 R2 R3 4K fault", 64'(o_fault), 64'd0);
        chk("R3 4K addr", 64'(o_addr), 64'(PG_A | 46'hABC));
        chk("R3 4K size", 64'(o_size), 64'd0);
        chk("R11 4K latency", 64'(o_lat), 64'd13);
        chk("R3 4K reads", 64'(o_reads), 64'd6);
        chk("R10 busy ready low", 64'(o_busy_bad), 64'd0);
        chk("R10 result held", 64'(o_hold_bad), 64'd0);
        chk("R10 idle after take", 64'(o_idle_after), 64'd1);
    endtask

    task automatic t_sp_1g;
        logic [63:0] a = va(1, 2, 3, 4, 'h123);
        run({8'd5, 8'h1B}, a, 1'b0, 0);
        chk("R4 1G addr", 64'(o_addr), 64'(G1_B | 46'(a[29:0])));
        chk("R4 1G size", 64'(o_size), 64'd2);
        chk("R4 1G latency", 64'(o_lat), 64'd9);
    endtask

    task automatic t_sp_2m;
        logic [63:0] a = va(1, 5, 6, 7, 'h456);
        run({8'd5, 8'h1B}, a, 1'b0, 0);
        chk("R4 2M addr", 64'(o_addr), 64'(M2_B | 46'(a[20:0])));
        chk("R4 2M size", 64'(o_size), 64'd1);
        chk("R4 2M latency", 64'(o_lat), 64'd11);
    endtask

    task automatic t_sp_off;
        cfg_sp_en = 1'b0;
        run({8'd5, 8'h1B}, va(1, 2, 3, 4, 'h123), 1'b0, 0);
        cfg_sp_en = 1'b1;
        chk("R5 sp off fault", 64'(o_fault), 64'd1);
        chk("R5 sp off code", 64'(o_code), 64'd2);
        chk("R5 sp off latency", 64'(o_lat), 64'd11);
    endtask

    task automatic t_faults;
        run({8'd9, 8'h1A}, va(1, 2, 3, 4, 0), 1'b0, 0);
        chk("R6 R1 root code", {o_fault, o_code}, 64'({1'b1, 2'd0}));
        chk("R6 root addr zero", 64'(o_addr), 64'd0);
        chk("R11 root latency", 64'(o_lat), 64'd3);
        run({8'd5, 8'h20}, va(1, 2, 3, 4, 0), 1'b0, 0);
        chk("R6 R2 ctx code", {o_fault, o_code}, 64'({1'b1, 2'd1}));
        chk("R11 ctx latency", 64'(o_lat), 64'd5);
        run({8'd5, 8'h1A}, va(7, 2, 3, 4, 0), 1'b0, 0);
        chk("R6 pte code", {o_fault, o_code}, 64'({1'b1, 2'd2}));
        chk("R11 pte latency", 64'(o_lat), 64'd7);
    endtask

    task automatic t_width;
        run({8'd5, 8'h1A}, 64'h0001_0000_0000_1000, 1'b0, 0);
        chk("R7 width code", {o_fault, o_code}, 64'({1'b1, 2'd3}));
        chk("R7 width no reads", 64'(o_reads), 64'd0);
        chk("R7 width latency", 64'(o_lat), 64'd1);
        run({8'd5, 8'h1C}, 64'h0000_7000_0000_0000, 1'b0, 0);
        chk("R7 flat wide code", {o_fault, o_code}, 64'({1'b1, 2'd3}));
    endtask

    task automatic t_flat;
        run({8'd5, 8'h1C}, 64'h0000_2345_6789_ABCD, 1'b0, 0);
        chk("R9 flat addr", 64'(o_addr), 64'h0000_2345_6789_ABCD);
        chk("R9 flat size", {o_fault, o_size}, 64'({1'b0, 2'd3}));
        chk("R9 flat latency", 64'(o_lat), 64'd5);
    endtask

    task automatic t_msi;
        run({8'd9, 8'h00}, 64'h0000_0000_FEE0_1000, 1'b1, 0);
        chk("R8 msi addr", 64'(o_addr), 64'hFEE0_1000);
        chk("R8 msi size", {o_fault, o_size}, 64'({1'b0, 2'd3}));
        chk("R8 msi no reads", 64'(o_reads), 64'd0);
        chk("R8 msi latency", 64'(o_lat), 64'd1);
        run({8'd9, 8'h00}, 64'h0000_0000_FEE0_1000, 1'b0, 0);
        chk("R8 msi read walks", {o_fault, o_code}, 64'({1'b1, 2'd0}));
        chk("R8 msi read reads", 64'(o_reads), 64'd1);
    endtask

    task automatic t_stall;
        stall_req = 3;
        run({8'd9, 8'h00}, va(1, 2, 3, 4, 0), 1'b0, 0);
        stall_req = 0;
        chk("R12 stall code", {o_fault, o_code}, 64'({1'b1, 2'd0}));
        chk("R12 stall latency", 64'(o_lat), 64'd6);
    endtask

    initial begin
        mem[cfg_root_base + 46'd5*8]  = 64'(CTX_A) | 64'h1;
        mem[CTX_A + 46'h1A*8]         = 64'(PT4_A) | 64'h1;
        mem[PT4_A + 46'd1*8]          = 64'(PT3_A) | 64'h1;
        mem[PT3_A + 46'd2*8]          = 64'(PT2_A) | 64'h1;
        mem[PT2_A + 46'd3*8]          = 64'(PT1_A) | 64'h1;
        mem[PT1_A + 46'd4*8]          = 64'(PG_A)  | 64'h1;
        mem[CTX_A + 46'h1B*8]         = 64'(PT4_B) | 64'h1;
        mem[PT4_B + 46'd1*8]          = 64'(PT3_B) | 64'h1;
        mem[PT3_B + 46'd2*8]          = 64'(G1_B)  | 64'h81;
        mem[PT3_B + 46'd5*8]          = 64'(PT2_B) | 64'h1;
        mem[PT2_B + 46'd6*8]          = 64'(M2_B)  | 64'h81;
        mem[CTX_A + 46'h1C*8]         = 64'h3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walk_4k();
        t_sp_1g();
        t_sp_2m();
        t_sp_off();
        t_faults();
        t_width();
        t_flat();
        t_msi();
        t_stall();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule